// File: doc/BRIEF.md
# Vector Source Operand Conditioner

This block prepares one 128-bit source operand on its way into a vector arithmetic unit. In one pass it rearranges the operand in three steps. First it copies or exchanges the two 64-bit halves, or it widens the half-width elements of one chosen half to full lane width. Next it routes the four 32-bit components through a per-component swizzle. Last, for float operands, it clears or flips the sign bit of every lane.

All control arrives alongside the data in the same cycle. That control is a 3-bit expand mode, a 2-bit modifier, an 8-bit swizzle, a lane-width code and an integer/float flag. The 2-bit modifier is read two ways. For integer operands it chooses how a widened element fills its lane. For float operands it is an absolute-value and negate pair. The conditioned vector leaves the block from a register, one clock after the input, together with a valid flag.

Top module: `vsrc_cond`

## Requirements
- R1: The output is registered. `out_valid` equals the `in_valid` of the previous clock. `out_data` loads the conditioned vector only when `in_valid` is high and holds its value otherwise. A synchronous reset (`rst_n` low) clears both outputs to zero.
- R2: Expand modes 0 to 3 act on the 64-bit halves (low = bits 63:0, high = bits 127:64). Mode 0 passes the operand unchanged. Mode 1 gives {low, low}. Mode 2 gives {high, high}. Mode 3 gives {low, high}, which exchanges the halves.
- R3: Expand modes 4 to 7 widen elements. The source half is the low half when mode bit 0 is 0 and the high half when it is 1. Lane k of the result is built from element k of that half, and an element is half as wide as a lane. `lane_mode` sets the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Modes 6 and 7 exchange the two 64-bit halves of the widened result.
- R4: For an integer operand in a widening mode, the modifier fills the lane as follows: 0 = sign extend, 1 = zero extend, 2 = the element in both halves of the lane, 3 = the element in the upper half with zeros below.
- R5: For an integer operand in modes 0 to 3, the modifier has no effect.
- R6: For a float operand in a widening mode, the element goes into the upper half of its lane with zeros below, whatever the modifier value.
- R7: The swizzle holds four 2-bit selectors. The selector at swizzle[2i+1:2i] picks which 32-bit component feeds output component i. Value 8'hE4 is the identity. The swizzle acts after the expand step and before the sign step.
- R8: For a float operand, modifier bit 0 clears the sign bit (bit L-1 of each lane of width L) and modifier bit 1 then flips it, so both bits together set it. The sign step applies in every expand mode. Integer operands never get this step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operand present this cycle |
| in_data | input | 128 | Raw source vector |
| expand_mode | input | 3 | Half copy/exchange or widening selection |
| modifier | input | 2 | Integer fill kind or float abs/neg bits |
| swizzle | input | 8 | Four 2-bit component selectors |
| lane_mode | input | 2 | Lane width code: 8/16/32/64 bits |
| is_float | input | 1 | 1 = float operand, 0 = integer |
| out_valid | output | 1 | Registered valid |
| out_data | output | 128 | Registered conditioned vector |

## Verification
The interesting collision is widening with a post-widen half exchange landing in the same cycle as a non-identity swizzle and a float sign change. A float operand is driven in mode 7 with a reversing swizzle and both sign bits set, in each lane width. The bench compares the registered result against a bit-level model written directly from the requirements. This shows whether the exchange comes before the swizzle, and whether the sign position follows the lane width and not the 32-bit component boundary.

// File: rtl/vsc_pkg.sv
// Package: shared constants and encodings for the vector source conditioner.
// Assumes a 128-bit operand built from two 64-bit halves and four 32-bit components.
package vsc_pkg;

    localparam int VEC_W   = 128;
    localparam int COMP_W  = 32;
    localparam int NUM_LW  = 4;   // number of lane width codes

    // Expand step selection; the numeric codes are decoded by the operand source.
    typedef enum logic [2:0] {
        XP_PASS       = 3'd0,
        XP_DUP_LO     = 3'd1,
        XP_DUP_HI     = 3'd2,
        XP_SWAP       = 3'd3,
        XP_WIDE_LO    = 3'd4,
        XP_WIDE_HI    = 3'd5,
        XP_WIDE_LO_SW = 3'd6,
        XP_WIDE_HI_SW = 3'd7
    } xp_mode_e;

    // Integer lane fill kind applied while widening.
    typedef enum logic [1:0] {
        FILL_SEXT  = 2'd0,
        FILL_ZEXT  = 2'd1,
        FILL_REPL  = 2'd2,
        FILL_UPPER = 2'd3
    } fill_kind_e;

    // Float modifier bit positions.
    localparam int FMOD_ABS_BIT = 0;
    localparam int FMOD_NEG_BIT = 1;

endpackage

// File: rtl/vsc_expand.sv
// Module: vsc_expand
// Copies or exchanges the 64-bit halves, or widens the half-width elements of
// one half to full lane width, then optionally exchanges the widened halves.
// Assumes DATA_W is 128 so that all four lane width codes (8..64) fit.
module vsc_expand
    import vsc_pkg::*;
#(
    parameter int DATA_W = VEC_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [2:0]        mode,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        fill_sel,
    input  logic              is_float,
    output logic [DATA_W-1:0] dout
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0]               lo_h;
    logic [HALF_W-1:0]               hi_h;
    logic [HALF_W-1:0]               src_h;
    logic [1:0]                      fill_eff;
    logic [NUM_LW-1:0][DATA_W-1:0]   wide;
    logic [DATA_W-1:0]               wide_sel;

    assign lo_h     = din[HALF_W-1:0];
    assign hi_h     = din[DATA_W-1:HALF_W];
    // mode bit 0 picks the source half for widening
    assign src_h    = mode[0] ? hi_h : lo_h;
    // float widening always places the element high with zeros below
    assign fill_eff = is_float ? 2'(FILL_UPPER) : fill_sel;

    // one widening network per lane width code
    for (genvar g = 0; g < NUM_LW; g++) begin : g_lw
        localparam int LW  = 8 << g;
        localparam int EW  = LW / 2;
        localparam int NLN = DATA_W / LW;
        for (genvar k = 0; k < NLN; k++) begin : g_lane
            logic [EW-1:0] elem;
            assign elem = src_h[k*EW +: EW];
            assign wide[g][k*LW +: LW] =
                (fill_eff == 2'(FILL_SEXT)) ? {{EW{elem[EW-1]}}, elem} :
                (fill_eff == 2'(FILL_ZEXT)) ? {{EW{1'b0}}, elem} :
                (fill_eff == 2'(FILL_REPL)) ? {elem, elem} :
                                              {elem, {EW{1'b0}}};
        end
    end

    assign wide_sel = wide[lane_mode];

    // select the final arrangement of halves for the chosen expand mode
    always_comb begin
        case (xp_mode_e'(mode))
            XP_PASS:       dout = din;
            XP_DUP_LO:     dout = {lo_h, lo_h};
            XP_DUP_HI:     dout = {hi_h, hi_h};
            XP_SWAP:       dout = {lo_h, hi_h};
            XP_WIDE_LO,
            XP_WIDE_HI:    dout = wide_sel;
            default:       dout = {wide_sel[HALF_W-1:0], wide_sel[DATA_W-1:HALF_W]};
        endcase
    end

endmodule

// File: rtl/vsc_swizzle.sv
// Module: vsc_swizzle
// Routes whole components: output component i takes the input component named
// by selector i. Assumes the component count is a power of two.
module vsc_swizzle
    import vsc_pkg::*;
#(
    parameter int DATA_W = VEC_W,
    parameter int CW     = COMP_W,
    localparam int NC    = DATA_W / CW,
    localparam int SELW  = $clog2(NC),
    localparam int SWZW  = NC * SELW
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SWZW-1:0]   swz,
    output logic [DATA_W-1:0] dout
);
    // one multiplexer per output component
    for (genvar i = 0; i < NC; i++) begin : g_comp
        logic [SELW-1:0] sel;
        assign sel = swz[i*SELW +: SELW];
        assign dout[i*CW +: CW] = din[sel*CW +: CW];
    end

endmodule

// File: rtl/vsc_signmod.sv
// Module: vsc_signmod
// Float sign step: abs clears, then neg flips, the top bit of every lane.
// The lane width follows lane_mode. Integer operands pass unchanged.
module vsc_signmod
    import vsc_pkg::*;
#(
    parameter int DATA_W = VEC_W
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        lane_mode,
    input  logic [1:0]        fmod,
    input  logic              is_float,
    output logic [DATA_W-1:0] dout
);
    logic [NUM_LW-1:0][DATA_W-1:0] masks;
    logic [DATA_W-1:0]             smask;
    logic [DATA_W-1:0]             clr_m;
    logic [DATA_W-1:0]             flp_m;

    // constant sign-bit mask for each lane width
    for (genvar g = 0; g < NUM_LW; g++) begin : g_lw
        localparam int LW  = 8 << g;
        localparam int NLN = DATA_W / LW;
        for (genvar k = 0; k < NLN; k++) begin : g_lane
            assign masks[g][k*LW +: LW] = {1'b1, {(LW-1){1'b0}}};
        end
    end

    assign smask = masks[lane_mode];
    assign clr_m = (is_float && fmod[FMOD_ABS_BIT]) ? smask : '0;
    assign flp_m = (is_float && fmod[FMOD_NEG_BIT]) ? smask : '0;

    // apply abs before neg
    always_comb begin
        dout = (din & ~clr_m) ^ flp_m;
    end

endmodule

// File: rtl/vsrc_cond.sv
// Module: vsrc_cond (top)
// Conditions a vector source operand in three steps: expand/exchange, then
// swizzle, then float sign. The result is registered with a valid flag.
// Assumes the control is stable for the cycle in which in_valid is high.
module vsrc_cond
    import vsc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [127:0] in_data,
    input  logic [2:0]   expand_mode,
    input  logic [1:0]   modifier,
    input  logic [7:0]   swizzle,
    input  logic [1:0]   lane_mode,
    input  logic         is_float,
    output logic         out_valid,
    output logic [127:0] out_data
);
    logic [VEC_W-1:0] xp_q;
    logic [VEC_W-1:0] sw_q;
    logic [VEC_W-1:0] sg_q;

    vsc_expand #(.DATA_W(VEC_W)) u_expand (
        .din       (in_data),
        .mode      (expand_mode),
        .lane_mode (lane_mode),
        .fill_sel  (modifier),
        .is_float  (is_float),
        .dout      (xp_q)
    );

    vsc_swizzle #(.DATA_W(VEC_W), .CW(COMP_W)) u_swizzle (
        .din  (xp_q),
        .swz  (swizzle),
        .dout (sw_q)
    );

    vsc_signmod #(.DATA_W(VEC_W)) u_signmod (
        .din       (sw_q),
        .lane_mode (lane_mode),
        .fmod      (modifier),
        .is_float  (is_float),
        .dout      (sg_q)
    );

    // output register: valid follows input, data loads only on valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= sg_q;
            end
        end
    end

endmodule

// File: rtl/vsc_checker.sv
// Module: vsc_checker
// Temporal checks on the conditioner's ports, attached by bind.
module vsc_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] in_data,
    input logic [2:0]   expand_mode,
    input logic [1:0]   modifier,
    input logic [7:0]   swizzle,
    input logic [1:0]   lane_mode,
    input logic         is_float,
    input logic         out_valid,
    input logic [127:0] out_data
);
    // R1: reset clears valid on the next edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R1: valid follows the input one cycle later
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: data holds while no input arrives
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && rst_n) |=> $stable(out_data));

    // R2: plain integer pass with identity swizzle reproduces the input
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && expand_mode == 3'd0 && swizzle == 8'hE4 && !is_float)
        |=> out_data == $past(in_data));

    // R2: half exchange with identity swizzle
    a_r2_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && expand_mode == 3'd3 && swizzle == 8'hE4 && !is_float)
        |=> out_data == {$past(in_data[63:0]), $past(in_data[127:64])});

    // R7: an all-zero swizzle broadcasts component 0 in pass mode
    a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && expand_mode == 3'd0 && swizzle == 8'h00 && !is_float)
        |=> out_data == {4{$past(in_data[31:0])}});

    // R8: float abs alone on 32-bit lanes leaves every sign bit clear
    a_r8_abs32: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_float && modifier == 2'd1 && lane_mode == 2'd2)
        |=> (!out_data[31] && !out_data[63] && !out_data[95] && !out_data[127]));

endmodule

bind vsrc_cond vsc_checker u_chk (.*);

// File: tb/sim_vsrc_cond.sv
`timescale 1ns/1ps
module sim_vsrc_cond;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_data;
    logic [2:0]   expand_mode;
    logic [1:0]   modifier;
    logic [7:0]   swizzle;
    logic [1:0]   lane_mode;
    logic         is_float;
    logic         out_valid;
    logic [127:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    vsrc_cond u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .expand_mode(expand_mode), .modifier(modifier), .swizzle(swizzle),
        .lane_mode(lane_mode), .is_float(is_float),
        .out_valid(out_valid), .out_data(out_data)
    );

    // bit-level model written from the requirements
    function automatic logic [127:0] model(input logic [127:0] d, input logic [2:0] m,
                                           input logic [1:0] md, input logic [7:0] sw,
                                           input logic [1:0] lm, input logic f);
        logic [127:0] a;
        logic [127:0] b;
        logic [63:0]  half;
        logic [1:0]   fk;
        int L;
        int E;
        L = 8 << lm;
        E = L / 2;
        a = '0;
        half = m[0] ? d[127:64] : d[63:0];
        fk = f ? 2'd3 : md;
        if (m == 3'd0) a = d;
        else if (m == 3'd1) a = {d[63:0], d[63:0]};
        else if (m == 3'd2) a = {d[127:64], d[127:64]};
        else if (m == 3'd3) a = {d[63:0], d[127:64]};
        else begin
            for (int k = 0; k < 128 / L; k++) begin
                for (int j = 0; j < L; j++) begin
                    case (fk)
                        2'd0: a[k*L+j] = (j < E) ? half[k*E+j] : half[k*E+E-1];
                        2'd1: a[k*L+j] = (j < E) ? half[k*E+j] : 1'b0;
                        2'd2: a[k*L+j] = half[k*E + (j % E)];
                        default: a[k*L+j] = (j < E) ? 1'b0 : half[k*E+j-E];
                    endcase
                end
            end
            if (m[1]) a = {a[63:0], a[127:64]};
        end
        for (int i = 0; i < 4; i++) b[i*32 +: 32] = a[sw[2*i +: 2]*32 +: 32];
        if (f) begin
            for (int k = 0; k < 128 / L; k++) begin
                if (md[0]) b[k*L+L-1] = 1'b0;
                if (md[1]) b[k*L+L-1] = ~b[k*L+L-1];
            end
        end
        return b;
    endfunction

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive one operand at a falling edge; return at the falling edge after capture
    task automatic apply(input logic [127:0] d, input logic [2:0] m, input logic [1:0] md,
                         input logic [7:0] sw, input logic [1:0] lm, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; expand_mode = m; modifier = md;
        swizzle = sw; lane_mode = lm; is_float = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input string tag, input logic [127:0] d, input logic [2:0] m,
                       input logic [1:0] md, input logic [7:0] sw, input logic [1:0] lm,
                       input logic f);
        apply(d, m, md, sw, lm, f);
        check(tag, out_data, model(d, m, md, sw, lm, f));
        check({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    endtask

    localparam logic [127:0] PAT = 128'h89AB_CDEF_0123_4567_FEDC_BA98_7654_3210;

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; expand_mode = '0;
        modifier = '0; swizzle = 8'hE4; lane_mode = 2'd2; is_float = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset data", out_data, 128'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_halves();
        for (int m = 0; m < 4; m++) run("R2 halves", PAT, 3'(m), 2'd0, 8'hE4, 2'd2, 1'b0);
        apply(PAT, 3'd3, 2'd0, 8'hE4, 2'd2, 1'b0);
        check("R2 swap literal", out_data, {PAT[63:0], PAT[127:64]});
    endtask

    task automatic t_widen_int();
        apply(128'h0000_1234_0000_8001, 3'd4, 2'd0, 8'hE4, 2'd2, 1'b0);
        check("R4 sext literal", out_data, 128'h00000000_00001234_00000000_FFFF8001);
        for (int lm = 0; lm < 4; lm++)
            for (int md = 0; md < 4; md++)
                for (int m = 4; m < 8; m++)
                    run("R3 R4 widen int", PAT, 3'(m), 2'(md), 8'hE4, 2'(lm), 1'b0);
    endtask

    task automatic t_nowiden_mod();
        for (int md = 0; md < 4; md++) begin
            apply(PAT, 3'd2, 2'(md), 8'hE4, 2'd1, 1'b0);
            check("R5 int modifier ignored", out_data, {PAT[127:64], PAT[127:64]});
        end
    endtask

    task automatic t_widen_float();
        apply(128'h0000_0000_0000_0000_0000_0000_0000_ABCD, 3'd4, 2'd0, 8'hE4, 2'd2, 1'b1);
        check("R6 float widen literal", out_data, 128'h0000_0000_ABCD_0000);
        for (int lm = 0; lm < 4; lm++)
            run("R6 float widen", PAT, 3'd5, 2'd0, 8'hE4, 2'(lm), 1'b1);
    endtask

    task automatic t_swizzle();
        apply(128'h33333333_22222222_11111111_00000000, 3'd0, 2'd0, 8'h1B, 2'd2, 1'b0);
        check("R7 reverse", out_data, 128'h00000000_11111111_22222222_33333333);
        run("R7 swizzle after swap", PAT, 3'd3, 2'd0, 8'h4E, 2'd2, 1'b0);
        run("R7 swizzle after widen", PAT, 3'd6, 2'd2, 8'h93, 2'd1, 1'b0);
    endtask

    task automatic t_float_signs();
        apply({4{32'h8000_0001}}, 3'd0, 2'd1, 8'hE4, 2'd2, 1'b1);
        check("R8 abs literal", out_data, {4{32'h0000_0001}});
        apply({8{16'h0005}}, 3'd0, 2'd2, 8'hE4, 2'd1, 1'b1);
        check("R8 neg literal", out_data, {8{16'h8005}});
        apply({8{16'h0005}}, 3'd0, 2'd2, 8'hE4, 2'd1, 1'b0);
        check("R8 no sign step on int", out_data, {8{16'h0005}});
        for (int lm = 0; lm < 4; lm++)
            for (int md = 1; md < 4; md++)
                run("R8 float sign", PAT, 3'd1, 2'(md), 8'hE4, 2'(lm), 1'b1);
    endtask

    task automatic t_hold();
        logic [127:0] prev;
        apply(PAT, 3'd0, 2'd0, 8'hE4, 2'd2, 1'b0);
        prev = out_data;
        @(negedge clk);
        in_data = ~PAT;
        @(negedge clk);
        check("R1 hold data", out_data, prev);
        check("R1 valid low", {127'd0, out_valid}, 128'd0);
    endtask

    task automatic t_combined();
        for (int lm = 0; lm < 4; lm++) begin
            run("R3 R7 R8 combined", PAT, 3'd7, 2'd3, 8'h1B, 2'(lm), 1'b1);
            run("R3 R7 R8 combined neg", ~PAT, 3'd6, 2'd2, 8'h39, 2'(lm), 1'b1);
        end
    endtask

    initial begin
        t_reset();
        t_halves();
        t_widen_int();
        t_nowiden_mod();
        t_widen_float();
        t_swizzle();
        t_float_signs();
        t_hold();
        t_combined();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule